// File: doc/BRIEF.md
# Block-Transfer DMA Controller

This controller copies a block of words between memory and a single device data port, so the processor does not have to move each word itself. The processor writes three values before it starts a transfer: the first memory address, the number of words, and a direction bit with an interrupt-enable bit. A write to the go selector then starts the transfer. The controller asks for the bus and waits for the grant. It then moves one word per accepted beat. After each word it steps the address up by one and the remaining count down by one. When the count reaches zero it frees the bus and raises a completion flag. If interrupts are enabled, it also raises an interrupt.

A device-side ready line paces the beats. In memory-to-device mode, ready means the device can take a word. In device-to-memory mode, it means the device has a word on its data lines. Memory is taken as a single-cycle port: read data is valid in the same cycle as the read strobe, and a write happens at the clock edge at the end of the strobe cycle.

The controller has three states. IDLE is the rest state. WAIT_GNT holds the bus request until the grant arrives. MOVE performs the word beats. The transitions are:
- IDLE to IDLE on go with a zero count ("instant done").
- IDLE to WAIT_GNT on go with a nonzero count ("launch").
- WAIT_GNT to MOVE when the grant is seen ("granted").
- MOVE to MOVE on a stalled beat or on any beat that is not the last ("stall/step").
- MOVE to IDLE on the beat that carries the last word ("finish").

Top module: `blkdma_top`

## Requirements
- R1: After reset the controller is idle. `bus_req`, `xfer_done`, `irq` and `dev_stb` are all 0.
- R2: A go write with a nonzero count raises `bus_req`. No memory strobe appears while `bus_gnt` is low, and `bus_req` stays high during every word beat.
- R3: Word beats drive `mem_addr` with the programmed start address on the first beat. The address rises by one on each later beat, and exactly the programmed count of beats occurs.
- R4: With direction bit 1 (memory to device), each beat asserts `mem_rd` with `mem_wr` low, and `dev_dout` carries `mem_rdata`.
- R5: With direction bit 0 (device to memory), each beat asserts `mem_wr` with `mem_rd` low, and `mem_wdata` carries `dev_din`.
- R6: While `dev_rdy` is low, no beat happens and the address holds.
- R7: `bus_req` is low in the cycle after the last beat, and `xfer_done` is 1 in that cycle.
- R8: `irq` is 1 exactly when `xfer_done` is 1 and the interrupt-enable bit is set.
- R9: A `stat_rd` pulse clears `xfer_done`, and with it `irq`.
- R10: A go write with a count of 0 sets `xfer_done` on the next cycle without ever raising `bus_req`.
- R11: Configuration writes are ignored while the controller is busy. This covers address, count, control and go. Selector encoding: 0 = start address, 1 = word count, 2 = control (bit 0 direction, bit 1 interrupt enable), 3 = go.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration selector (see R11) |
| cfg_wdata | input | AW | Configuration write data |
| stat_rd | input | 1 | Status read pulse, clears done |
| xfer_done | output | 1 | Completion flag |
| irq | output | 1 | Completion interrupt |
| bus_req | output | 1 | Bus mastership request |
| bus_gnt | input | 1 | Bus mastership grant |
| mem_addr | output | AW | Memory word address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data (same cycle) |
| dev_rdy | input | 1 | Device can accept (dir 1) or has data (dir 0) |
| dev_stb | output | 1 | One-cycle word beat toward the device |
| dev_dout | output | DW | Word to the device |
| dev_din | input | DW | Word from the device |

## Verification
A table of transfers covers both directions, several start addresses and counts, and ready patterns that are either always high or interleaved with stall cycles. Per-beat address and data checks separate a correct address walk from an off-by-one or a missing stall. The interleaved patterns show whether a low ready line really freezes the walk. Directed cases hold the grant low to show that no strobe leaks before mastership. Configuration writes made while the controller waits for the grant show whether they are ignored. A zero-count start shows completion with no bus request.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_GNT = 2'd1,
        ST_MOVE     = 2'd2
    } dma_state_e;

    localparam logic [1:0] SEL_ADDR  = 2'd0;
    localparam logic [1:0] SEL_COUNT = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;
    localparam logic [1:0] SEL_GO    = 2'd3;
endpackage

// File: rtl/blkdma_regs.sv
module blkdma_regs
    import blkdma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          busy,
    input  logic          step,
    output logic [AW-1:0] addr_q,
    output logic          dir_q,
    output logic          ien_q,
    output logic          go,
    output logic          cnt_zero,
    output logic          cnt_last
);
    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    logic [CW-1:0] cnt_q;
    logic          wr_ok;

    assign wr_ok    = cfg_wr && !busy;
    assign go       = wr_ok && (cfg_sel == SEL_GO);
    assign cnt_zero = (cnt_q == '0);
    assign cnt_last = (cnt_q == CNT_ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
            dir_q  <= 1'b0;
            ien_q  <= 1'b0;
        end else begin
            if (wr_ok && cfg_sel == SEL_ADDR)
                addr_q <= cfg_wdata;
            else if (step)
                addr_q <= addr_q + AW'(1);

            if (wr_ok && cfg_sel == SEL_COUNT)
                cnt_q <= cfg_wdata[CW-1:0];
            else if (step)
                cnt_q <= cnt_q - CNT_ONE;

            if (wr_ok && cfg_sel == SEL_CTRL) begin
                dir_q <= cfg_wdata[0];
                ien_q <= cfg_wdata[1];
            end
        end
    end

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !step) |=> $stable(addr_q));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (addr_q == AW'($past(addr_q) + AW'(1))));
endmodule

// File: rtl/blkdma_fsm.sv
module blkdma_fsm
    import blkdma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic cnt_zero,
    input  logic cnt_last,
    input  logic bus_gnt,
    input  logic dev_rdy,
    input  logic stat_rd,
    output logic bus_req,
    output logic busy,
    output logic step,
    output logic done
);
    dma_state_e state_q, state_d;
    logic       set_done;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (go && !cnt_zero) state_d = ST_WAIT_GNT;
            ST_WAIT_GNT: if (bus_gnt)         state_d = ST_MOVE;
            ST_MOVE:     if (step && cnt_last) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        bus_req  = (state_q == ST_WAIT_GNT) || (state_q == ST_MOVE);
        busy     = (state_q != ST_IDLE);
        step     = (state_q == ST_MOVE) && bus_gnt && dev_rdy;
        set_done = (go && cnt_zero) || (step && cnt_last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (set_done)
                done <= 1'b1;
            else if (stat_rd || go)
                done <= 1'b0;
        end
    end

    // R7
    last_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt_last) |=> (!bus_req && done));

    // R10
    zero_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && cnt_zero) |=> (done && !bus_req));

    // R9
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !go && !(step && cnt_last)) |=> !done);
endmodule

// File: rtl/blkdma_top.sv
module blkdma_top #(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          stat_rd,
    output logic          xfer_done,
    output logic          irq,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          dev_rdy,
    output logic          dev_stb,
    output logic [DW-1:0] dev_dout,
    input  logic [DW-1:0] dev_din
);
    logic busy, step, go, cnt_zero, cnt_last, dir_q, ien_q;

    blkdma_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .busy(busy), .step(step), .addr_q(mem_addr),
        .dir_q(dir_q), .ien_q(ien_q), .go(go), .cnt_zero(cnt_zero),
        .cnt_last(cnt_last)
    );

    blkdma_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .go(go), .cnt_zero(cnt_zero),
        .cnt_last(cnt_last), .bus_gnt(bus_gnt), .dev_rdy(dev_rdy),
        .stat_rd(stat_rd), .bus_req(bus_req), .busy(busy), .step(step),
        .done(xfer_done)
    );

    assign mem_rd    = step && dir_q;
    assign mem_wr    = step && !dir_q;
    assign mem_wdata = dev_din;
    assign dev_dout  = mem_rdata;
    assign dev_stb   = step;
    assign irq       = xfer_done && ien_q;

    // R2
    strobe_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (bus_gnt && bus_req));
endmodule

// File: tb/sim_blkdma_top.sv
`timescale 1ns/1ps
module sim_blkdma_top;
    localparam int AW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          stat_rd = 1'b0;
    logic          xfer_done, irq, bus_req;
    logic          bus_gnt = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_rd, mem_wr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          dev_rdy = 1'b0;
    logic          dev_stb;
    logic [DW-1:0] dev_dout;
    logic [DW-1:0] dev_din = '0;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    logic [DW-1:0] mem [16];
    initial for (int i = 0; i < 16; i++) mem[i] = DW'(8'hA0 + i);
    always @(posedge clk) if (mem_wr) mem[mem_addr[3:0]] <= mem_wdata;
    assign mem_rdata = mem[mem_addr[3:0]];

    blkdma_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .stat_rd(stat_rd), .xfer_done(xfer_done),
        .irq(irq), .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .dev_rdy(dev_rdy), .dev_stb(dev_stb),
        .dev_dout(dev_dout), .dev_din(dev_din)
    );

    // {dir, ien, start[7:0], count[7:0], ready pattern[7:0]}
    localparam logic [25:0] VEC [4] = '{
        {1'b1, 1'b1, 8'd0,  8'd4, 8'hFF},
        {1'b1, 1'b0, 8'd3,  8'd3, 8'h55},
        {1'b0, 1'b1, 8'd8,  8'd5, 8'hFF},
        {1'b0, 1'b1, 8'd12, 8'd2, 8'h33}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [AW-1:0] val);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic program_xfer(input logic dir, input logic ien,
                                input logic [7:0] start, input logic [7:0] cnt);
        cfg_write(2'd0, AW'(start));
        cfg_write(2'd1, AW'(cnt));
        cfg_write(2'd2, AW'({ien, dir}));
        cfg_write(2'd3, '0);
    endtask

    task automatic observe(input logic dir, input logic ien, input logic [7:0] start,
                           input logic [7:0] cnt, input logic [7:0] pat);
        int k = 0;
        for (int cyc = 0; cyc < 64 && k < int'(cnt); cyc++) begin
            @(negedge clk);
            dev_rdy = pat[cyc % 8];
            dev_din = DW'(8'h50 + k);
            #1;
            if (!dev_rdy) chk("R6 stall gives no beat", 32'(dev_stb), 32'd0);
            if (dev_stb) begin
                chk("R3 beat address", 32'(mem_addr), 32'(start) + 32'(k));
                chk("R2 request held in beat", 32'(bus_req), 32'd1);
                if (dir) begin
                    chk("R4 read strobes", 32'({mem_rd, mem_wr}), 32'b10);
                    chk("R4 device word", 32'(dev_dout), 32'(8'hA0 + start + 8'(k)));
                end else begin
                    chk("R5 write strobes", 32'({mem_rd, mem_wr}), 32'b01);
                    chk("R5 memory word", 32'(mem_wdata), 32'(8'h50 + k));
                end
                k++;
            end
        end
        chk("R3 beat count", 32'(k), 32'(cnt));
        @(negedge clk);
        dev_rdy = 1'b0;
        #1;
        chk("R7 request released", 32'(bus_req), 32'd0);
        chk("R7 done after last", 32'(xfer_done), 32'd1);
        chk("R3 no extra beat", 32'(dev_stb), 32'd0);
        chk("R8 irq follows enable", 32'(irq), 32'(ien));
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        #1;
        chk("R9 status read clears done", 32'({xfer_done, irq}), 32'd0);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset outputs", 32'({bus_req, xfer_done, irq, dev_stb}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 idle after reset", 32'({bus_req, xfer_done, irq, dev_stb}), 32'd0);

        bus_gnt = 1'b1;
        foreach (VEC[v]) begin
            program_xfer(VEC[v][25], VEC[v][24], VEC[v][23:16], VEC[v][15:8]);
            observe(VEC[v][25], VEC[v][24], VEC[v][23:16], VEC[v][15:8], VEC[v][7:0]);
        end
        chk("R5 memory written", 32'(mem[13]), 32'h51);

        // zero-count start
        program_xfer(1'b1, 1'b1, 8'd2, 8'd0);
        #1;
        chk("R10 done at once", 32'(xfer_done), 32'd1);
        chk("R10 no request", 32'(bus_req), 32'd0);
        chk("R8 irq on zero count", 32'(irq), 32'd1);
        repeat (2) @(negedge clk);
        #1;
        chk("R10 request stays low", 32'(bus_req), 32'd0);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;

        // grant held off, writes while busy
        bus_gnt = 1'b0;
        program_xfer(1'b1, 1'b0, 8'd6, 8'd2);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            dev_rdy = 1'b1;
            #1;
            chk("R2 request while waiting", 32'(bus_req), 32'd1);
            chk("R2 no strobe without grant", 32'({mem_rd, mem_wr}), 32'd0);
        end
        cfg_write(2'd0, AW'(1));
        cfg_write(2'd1, AW'(7));
        cfg_write(2'd2, AW'(2'b10));
        cfg_write(2'd3, '0);
        dev_rdy = 1'b0;
        bus_gnt = 1'b1;
        observe(1'b1, 1'b0, 8'd6, 8'd2, 8'hFF);  // R11 original setup kept

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule